// File: doc/BRIEF.md
# Demand-Paged Address Translator

This block turns a logical address into a physical address for a demand-paged memory system. The address is split into a page number and a 9-bit offset within a 512-byte page. A register-based page table maps each page number to a frame number and a resident flag. A length register sets the highest page number the current process may use. Because every page and frame has the same fixed size, the table stores no per-entry limit.

Requests enter on a valid/ready stream. Each accepted request produces one response, one cycle later, on a second valid/ready stream. The response carries a status and, on success, the physical address. A reference to a page that is not resident stops further requests until software pulses a fault-clear input. Software uses that gap to bring the page in and update the table.

The request side follows these back-pressure rules:
- A request is taken on a clock edge where both `req_valid` and `req_ready` are high.
- `req_ready` is low while a response waits with `rsp_ready` low.
- `req_ready` is also low while a page fault is outstanding.
- A waiting response holds all of its fields unchanged until it is consumed.

Top module: `pgx_translator`

## Requirements
- R1: After reset, `rsp_valid` is 0 and `req_ready` is 1. Every table entry is non-resident and the length register is 0, so only page 0 is in range.
- R2: A request whose page is in range and resident returns status OK (code 0). Its physical address is the entry's frame number above the 9-bit offset, with the offset in bits [8:0].
- R3: A page number strictly greater than the length register returns status BOUNDS (code 1) with physical address 0, even when that entry is resident. A page number equal to the length register is in range.
- R4: An in-range page whose resident flag is clear returns status PAGE_FAULT (code 2) with physical address 0.
- R5: After a request that produced PAGE_FAULT is accepted, `req_ready` stays low until `fault_clr` is pulsed. `req_ready` is high again in the cycle after the pulse, provided the response slot is free.
- R6: While `rsp_valid` is high and `rsp_ready` is low, the response fields stay stable and `req_ready` is low.
- R7: A response appears in the cycle after acceptance. The lookup uses the table contents as they were before any table write made in the same cycle as the acceptance.
- R8: A table write sets the frame and resident flag of one entry, and a length write sets the length register. A later write that clears an entry's resident flag turns OK lookups of that entry into PAGE_FAULT.
- R9: A BOUNDS response does not stop later requests. `req_ready` returns to high once the response is consumed, without any `fault_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_page | input | PAGE_BITS | Logical page number |
| req_offset | input | 9 | Byte offset within the page |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_status | output | 2 | 0 OK, 1 BOUNDS, 2 PAGE_FAULT |
| rsp_paddr | output | FRAME_BITS+9 | Physical address, 0 on any fault |
| tbl_we | input | 1 | Write one page-table entry |
| tbl_idx | input | PAGE_BITS | Entry to write |
| tbl_frame | input | FRAME_BITS | Frame number to store |
| tbl_resident | input | 1 | Resident flag to store |
| len_we | input | 1 | Write the length register |
| len_value | input | PAGE_BITS | Highest legal page number |
| fault_clr | input | 1 | Pulse to release an outstanding page fault |

## Verification
The hardest states to reach are those that overlap. One is a stalled fault response that is held by back-pressure while `fault_clr` stays idle. Another is an acceptance in the same edge as a table write to the entry being looked up. Directed sequences line up those edges explicitly. Random traffic then reprograms the table and the length register between requests, so the three statuses and the equal-to-length boundary all recur many times.

// File: rtl/pgx_pkg.sv
package pgx_pkg;
  localparam int OFFSET_BITS = 9;

  typedef enum logic [1:0] {
    ST_OK     = 2'd0,
    ST_BOUNDS = 2'd1,
    ST_PFAULT = 2'd2
  } pgx_status_e;
endpackage

// File: rtl/pgx_table.sv
module pgx_table #(
  parameter int PAGE_BITS  = 4,
  parameter int FRAME_BITS = 7
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PAGE_BITS-1:0]  wr_idx,
  input  logic [FRAME_BITS-1:0] wr_frame,
  input  logic                  wr_res,
  input  logic                  len_we,
  input  logic [PAGE_BITS-1:0]  len_in,
  input  logic [PAGE_BITS-1:0]  rd_idx,
  output logic [FRAME_BITS-1:0] rd_frame,
  output logic                  rd_res,
  output logic [PAGE_BITS-1:0]  len_q
);
  localparam int NUM_PAGES = 1 << PAGE_BITS;

  logic [FRAME_BITS-1:0] frame_q [NUM_PAGES];
  logic [NUM_PAGES-1:0]  res_q;

  for (genvar i = 0; i < NUM_PAGES; i++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        frame_q[i] <= '0;
        res_q[i]   <= 1'b0;
      end else if (wr_en && (wr_idx == PAGE_BITS'(i))) begin
        frame_q[i] <= wr_frame;
        res_q[i]   <= wr_res;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '0;
    else if (len_we) len_q <= len_in;
  end

  assign rd_frame = frame_q[rd_idx];
  assign rd_res   = res_q[rd_idx];

  // R8
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (res_q[$past(wr_idx)] == $past(wr_res)) && (frame_q[$past(wr_idx)] == $past(wr_frame)));
endmodule

// File: rtl/pgx_check.sv
module pgx_check
  import pgx_pkg::*;
#(
  parameter int PAGE_BITS  = 4,
  parameter int FRAME_BITS = 7
) (
  input  logic [PAGE_BITS-1:0]             page,
  input  logic [OFFSET_BITS-1:0]           offset,
  input  logic [PAGE_BITS-1:0]             len,
  input  logic [FRAME_BITS-1:0]            frame,
  input  logic                             resident,
  output pgx_status_e                      status,
  output logic [FRAME_BITS+OFFSET_BITS-1:0] paddr
);
  // Offset width equals the page size, so no offset limit test exists.
  always_comb begin
    if (page > len) begin
      status = ST_BOUNDS;
      paddr  = '0;
    end else if (!resident) begin
      status = ST_PFAULT;
      paddr  = '0;
    end else begin
      status = ST_OK;
      paddr  = {frame, offset};
    end
  end
endmodule

// File: rtl/pgx_resp.sv
module pgx_resp
  import pgx_pkg::*;
#(
  parameter int PADDR_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  accept,
  input  pgx_status_e           in_status,
  input  logic [PADDR_BITS-1:0] in_paddr,
  input  logic                  rsp_ready,
  input  logic                  fault_clr,
  output logic                  can_accept,
  output logic                  rsp_valid,
  output pgx_status_e           rsp_status,
  output logic [PADDR_BITS-1:0] rsp_paddr
);
  logic fault_pend;

  assign can_accept = !fault_pend && (!rsp_valid || rsp_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_status <= ST_OK;
      rsp_paddr  <= '0;
    end else if (accept) begin
      rsp_valid  <= 1'b1;
      rsp_status <= in_status;
      rsp_paddr  <= in_paddr;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             fault_pend <= 1'b0;
    else if (accept && in_status == ST_PFAULT) fault_pend <= 1'b1;
    else if (fault_clr)                     fault_pend <= 1'b0;
  end

  // R6
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_status) && $stable(rsp_paddr));

  // R7
  one_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> rsp_valid);

  // R5
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && in_status == ST_PFAULT) |=> !can_accept);

  // R5
  release_needs_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault_pend) |-> $past(fault_clr));
endmodule

// File: rtl/pgx_translator.sv
module pgx_translator
  import pgx_pkg::*;
#(
  parameter int PAGE_BITS  = 4,
  parameter int FRAME_BITS = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_valid,
  output logic                              req_ready,
  input  logic [PAGE_BITS-1:0]              req_page,
  input  logic [8:0]                        req_offset,
  output logic                              rsp_valid,
  input  logic                              rsp_ready,
  output logic [1:0]                        rsp_status,
  output logic [FRAME_BITS+8:0]             rsp_paddr,
  input  logic                              tbl_we,
  input  logic [PAGE_BITS-1:0]              tbl_idx,
  input  logic [FRAME_BITS-1:0]             tbl_frame,
  input  logic                              tbl_resident,
  input  logic                              len_we,
  input  logic [PAGE_BITS-1:0]              len_value,
  input  logic                              fault_clr
);
  localparam int PADDR_BITS = FRAME_BITS + OFFSET_BITS;

  logic [FRAME_BITS-1:0] lk_frame;
  logic                  lk_res;
  logic [PAGE_BITS-1:0]  len_q;
  pgx_status_e           ck_status;
  logic [PADDR_BITS-1:0] ck_paddr;
  pgx_status_e           out_status;
  logic                  accept;

  assign accept = req_valid && req_ready;

  pgx_table #(.PAGE_BITS(PAGE_BITS), .FRAME_BITS(FRAME_BITS)) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_frame(tbl_frame), .wr_res(tbl_resident),
    .len_we(len_we), .len_in(len_value),
    .rd_idx(req_page), .rd_frame(lk_frame), .rd_res(lk_res), .len_q(len_q)
  );

  pgx_check #(.PAGE_BITS(PAGE_BITS), .FRAME_BITS(FRAME_BITS)) u_check (
    .page(req_page), .offset(req_offset), .len(len_q),
    .frame(lk_frame), .resident(lk_res),
    .status(ck_status), .paddr(ck_paddr)
  );

  pgx_resp #(.PADDR_BITS(PADDR_BITS)) u_resp (
    .clk(clk), .rst_n(rst_n), .accept(accept),
    .in_status(ck_status), .in_paddr(ck_paddr),
    .rsp_ready(rsp_ready), .fault_clr(fault_clr),
    .can_accept(req_ready), .rsp_valid(rsp_valid),
    .rsp_status(out_status), .rsp_paddr(rsp_paddr)
  );

  assign rsp_status = out_status;

  // R3
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status != 2'd0) |-> (rsp_paddr == '0));

  // R2
  offset_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (rsp_status != 2'd0) || (rsp_paddr[8:0] == $past(req_offset)));

  // R3
  bounds_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_page > len_q) |=> rsp_status == 2'd1);
endmodule

// File: tb/pgx_translator_tb.sv
module pgx_translator_tb;
  localparam int PB = 4;
  localparam int FB = 7;
  localparam int NP = 1 << PB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 0, rsp_ready = 1, tbl_we = 0, tbl_resident = 0, len_we = 0, fault_clr = 0;
  logic [PB-1:0] req_page = 0, tbl_idx = 0, len_value = 0;
  logic [8:0] req_offset = 0;
  logic [FB-1:0] tbl_frame = 0;
  logic req_ready, rsp_valid;
  logic [1:0] rsp_status;
  logic [FB+8:0] rsp_paddr;

  int checks = 0, errors = 0;
  logic [FB-1:0] m_frame [NP];
  logic [NP-1:0] m_res;
  logic [PB-1:0] m_len;

  always #2 clk = ~clk;

  pgx_translator #(.PAGE_BITS(PB), .FRAME_BITS(FB)) u_dut (.*);

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_st(input logic [PB-1:0] p);
    if (p > m_len) return 2'd1;
    if (!m_res[p]) return 2'd2;
    return 2'd0;
  endfunction

  function automatic logic [FB+8:0] exp_pa(input logic [PB-1:0] p, input logic [8:0] o);
    return (exp_st(p) == 2'd0) ? {m_frame[p], o} : '0;
  endfunction

  task automatic wr(input logic [PB-1:0] i, input logic [FB-1:0] f, input logic r);
    @(negedge clk); tbl_we = 1; tbl_idx = i; tbl_frame = f; tbl_resident = r;
    @(negedge clk); tbl_we = 0;
    m_frame[i] = f; m_res[i] = r;
  endtask

  task automatic set_len(input logic [PB-1:0] l);
    @(negedge clk); len_we = 1; len_value = l;
    @(negedge clk); len_we = 0;
    m_len = l;
  endtask

  task automatic clear_fault();
    @(negedge clk); fault_clr = 1;
    @(negedge clk); fault_clr = 0;
    chk("R5 ready after clear", req_ready, 1);
  endtask

  // Send one request, check its response at the following negedge.
  task automatic xlate(input logic [PB-1:0] p, input logic [8:0] o, input string tag);
    logic [1:0] es; logic [FB+8:0] ea;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    es = exp_st(p); ea = exp_pa(p, o);
    req_valid = 1; req_page = p; req_offset = o;
    @(negedge clk); req_valid = 0;
    chk({tag, " R7 valid"}, rsp_valid, 1);
    chk({tag, " status"}, rsp_status, es);
    chk({tag, " paddr"}, rsp_paddr, ea);
    if (es == 2'd2) begin
      @(negedge clk);
      chk("R5 stalled", req_ready, 0);
      clear_fault();
    end else if (es == 2'd1) begin
      @(negedge clk);
      chk("R9 no stall after bounds", req_ready, 1);
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    for (int i = 0; i < NP; i++) m_frame[i] = '0;
    m_res = '0; m_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 req_ready", req_ready, 1);
    xlate(0, 9'h1aa, "R1 R4 page0 after reset");
    xlate(1, 9'h003, "R1 R3 page1 after reset");

    // R2 basic and boundary equal to length
    set_len(5);
    wr(5, 7'h55, 1);
    wr(2, 7'h7f, 1);
    xlate(5, 9'h1ff, "R2 R3 page==len");
    xlate(2, 9'h000, "R2 offset zero");
    wr(6, 7'h11, 1);
    xlate(6, 9'h010, "R3 resident beyond len");
    xlate(3, 9'h0f0, "R4 nonresident");

    // R8 resident cleared later
    wr(2, 7'h7f, 0);
    xlate(2, 9'h044, "R8 cleared entry");

    // R5 fault held across extra cycles without clear
    @(negedge clk); req_valid = 1; req_page = 3; req_offset = 9'h1;
    @(negedge clk); req_valid = 0;
    chk("R4 status", rsp_status, 2);
    repeat (4) @(negedge clk);
    chk("R5 still stalled", req_ready, 0);
    clear_fault();

    // R6 back-pressure
    rsp_ready = 0;
    @(negedge clk); req_valid = 1; req_page = 5; req_offset = 9'h123;
    @(negedge clk); req_valid = 0;
    repeat (3) begin
      @(negedge clk);
      chk("R6 held valid", rsp_valid, 1);
      chk("R6 held paddr", rsp_paddr, {7'h55, 9'h123});
      chk("R6 ready low", req_ready, 0);
    end
    rsp_ready = 1;
    @(negedge clk);
    chk("R6 consumed", rsp_valid, 0);

    // R7 same-cycle write uses old contents
    @(negedge clk);
    req_valid = 1; req_page = 5; req_offset = 9'h00f;
    tbl_we = 1; tbl_idx = 5; tbl_frame = 7'h22; tbl_resident = 1;
    @(negedge clk); req_valid = 0; tbl_we = 0;
    chk("R7 old frame", rsp_paddr, {7'h55, 9'h00f});
    m_frame[5] = 7'h22;
    xlate(5, 9'h00f, "R7 R8 new frame");

    // random traffic
    for (int n = 0; n < 200; n++) begin
      int k = $urandom_range(0, 9);
      if (k < 3) wr(PB'($urandom), FB'($urandom), 1'($urandom));
      else if (k == 3) set_len(PB'($urandom));
      else xlate(PB'($urandom), 9'($urandom), "R2 R3 R4 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule